// File: doc/BRIEF.md
# Multi-Mode Port Pin Controller

This block controls a port of up to eight pins through a bank of per-pin control registers, reached over a simple register bus: a 3-bit address, a write strobe, write data and combinational read data. Each pin is either a plain port pin or an LCD segment pin. In port mode the block works out the pad's output value and output enable from the pin's data latch, tristate flag, special-function flag and double pull-down flag. When the special-function flag is set, an alternate-function input from a peripheral replaces the data latch as the value source. The double pull-down flag turns the pin into a pull-down-only driver for a wired-OR bus with an external pull-up.

When a pin is in LCD mode, its output driver is switched off. Its bits in the data, tristate, special and pull-down registers then hold the four phase bits of that segment line, and these go out on a segment bus to an LCD driver. Slow-drive and input-threshold flags pass straight to the pad as control outputs. A parameter gives the number of pins that really exist. Register bits of the missing pins cannot be stored, read back as zero and drive nothing.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register is 0. Each implemented pin is then in port mode, push-pull and fast, and is driven from its data latch: output enable 1, output value 0.
- R2: Register addresses: 0 mode (1 = LCD), 1 data latch, 2 tristate, 3 special select, 4 double pull-down, 5 slow, 6 input level. A write stores the write data at the next rising clock edge. Read data shows the addressed register combinationally, and address 7 reads as 0.
- R3: For pins at index NUM_PINS and above, writes have no effect and register reads return 0. These pins show 0 on the output value, output enable, slow, level and their segment nibble.
- R4: A pin in port mode, push-pull, with tristate 0 has output enable 1 and outputs its selected value.
- R5: A tristate bit of 1 forces the output enable of that pin to 0.
- R6: A special bit of 1 makes the pin's alt_in bit the selected value. A special bit of 0 makes the data latch the selected value.
- R7: With the double pull-down bit set in port mode and tristate 0, the output value is 0 and the output enable is the inverse of the selected value: driven low for 0, released for 1.
- R8: In LCD mode the pin's output enable and output value are 0. Segment bus bit 4*m+n carries phase n of pin m: n=0 data, n=1 tristate, n=2 special, n=3 pull-down register bit. A pin in port mode shows 0 on its segment nibble.
- R9: pad_slow and pad_lvl follow the slow and input-level registers of the implemented pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| alt_in | input | 8 | Alternate-function output values from peripherals |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_slow | output | 8 | Slow drive select per pin |
| pad_lvl | output | 8 | Automotive input threshold select per pin |
| seg_bus | output | 32 | Four phase bits per segment line |

## Verification
The bench runs with six implemented pins out of eight, so every write also checks that bits 6 and 7 are dropped. It first runs directed sequences: reset, plain push-pull, tristate, alternate-function selection with a toggling alt_in, pull-down with both value polarities, and LCD mode with distinct phase patterns. The distinct phase patterns show whether the segment bits are mixed up between phases or between lines. After that it applies long random streams of writes and alt_in changes, so that mixed combinations of flags per pin test whether the priority holds: LCD first, then tristate, then pull-down, then push-pull.

// File: rtl/gpio_port_pkg.sv
// Package: shared register addresses and constants for the port controller.
// Assumes: register bus address is 3 bits wide.
package gpio_port_pkg;

    localparam int REG_AW     = 3;
    localparam int NUM_REGS   = 7;
    localparam int NUM_PHASES = 4;

    typedef enum logic [REG_AW-1:0] {
        RA_MODE = 3'd0,
        RA_DATA = 3'd1,
        RA_TRI  = 3'd2,
        RA_SPEC = 3'd3,
        RA_DPD  = 3'd4,
        RA_SLOW = 3'd5,
        RA_LVL  = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;

    // Mask with the low n bits set, for up to 63 pins.
    function automatic logic [63:0] low_mask(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

endpackage

// File: rtl/gpio_regbank.sv
// Module: register bank holding seven per-pin control registers.
// Writes land on the rising edge; reads are combinational.
// Assumes: bits at or above NUM_PINS are never stored.
module gpio_regbank
    import gpio_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int NUM_PINS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [WIDTH-1:0]     wr_data,
    output logic [WIDTH-1:0]     rd_data,
    output logic [WIDTH-1:0]     mode_q,
    output logic [WIDTH-1:0]     data_q,
    output logic [WIDTH-1:0]     tri_q,
    output logic [WIDTH-1:0]     spec_q,
    output logic [WIDTH-1:0]     dpd_q,
    output logic [WIDTH-1:0]     slow_q,
    output logic [WIDTH-1:0]     lvl_q
);

    localparam logic [WIDTH-1:0] IMPL_MASK = WIDTH'(low_mask(NUM_PINS));

    logic [WIDTH-1:0] regs_q [NUM_REGS];

    // Store masked write data into the addressed register; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
        end else if (wr_en && (int'(addr) < NUM_REGS)) begin
            regs_q[addr] <= wr_data & IMPL_MASK;
        end
    end

    // Return the addressed register, zero for the unused address.
    always_comb begin
        if (int'(addr) < NUM_REGS) rd_data = regs_q[addr];
        else                       rd_data = '0;
    end

    assign mode_q = regs_q[RA_MODE];
    assign data_q = regs_q[RA_DATA];
    assign tri_q  = regs_q[RA_TRI];
    assign spec_q = regs_q[RA_SPEC];
    assign dpd_q  = regs_q[RA_DPD];
    assign slow_q = regs_q[RA_SLOW];
    assign lvl_q  = regs_q[RA_LVL];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_DATA) |=> (data_q == ($past(wr_data) & IMPL_MASK))); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && tri_q == '0 && dpd_q == '0 && spec_q == '0)); // R1

endmodule

// File: rtl/gpio_pin_drive.sv
// Module: output stage decision for one port pin.
// Priority: LCD mode, then tristate, then pull-down, then push-pull.
// Assumes: all inputs are settled register or peripheral values.
module gpio_pin_drive (
    input  logic lcd_mode,
    input  logic latch_val,
    input  logic tri_en,
    input  logic spec_en,
    input  logic dpd_en,
    input  logic alt_val,
    output logic pin_out,
    output logic pin_oe
);

    logic sel_val;

    // Pick the value source: peripheral or data latch.
    always_comb sel_val = spec_en ? alt_val : latch_val;

    // Work out the driver state from the mode flags.
    always_comb begin
        if (lcd_mode || tri_en) begin
            pin_out = 1'b0;
            pin_oe  = 1'b0;
        end else if (dpd_en) begin
            pin_out = 1'b0;
            pin_oe  = ~sel_val;
        end else begin
            pin_out = sel_val;
            pin_oe  = 1'b1;
        end
    end

endmodule

// File: rtl/gpio_seg_map.sv
// Module: gathers the four phase bits of each LCD segment line.
// Assumes: lines with mode 0 must present a zero nibble.
module gpio_seg_map
    import gpio_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int NUM_PINS = 8
) (
    input  logic [WIDTH-1:0]            mode_q,
    input  logic [WIDTH-1:0]            ph0,
    input  logic [WIDTH-1:0]            ph1,
    input  logic [WIDTH-1:0]            ph2,
    input  logic [WIDTH-1:0]            ph3,
    output logic [NUM_PHASES*WIDTH-1:0] seg
);

    for (genvar m = 0; m < WIDTH; m++) begin : g_line
        if (m < NUM_PINS) begin : g_impl
            // Gate the line's phases with its mode flag.
            assign seg[NUM_PHASES*m +: NUM_PHASES] =
                mode_q[m] ? {ph3[m], ph2[m], ph1[m], ph0[m]} : '0;
        end else begin : g_absent
            assign seg[NUM_PHASES*m +: NUM_PHASES] = '0;
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: top of the multi-mode port controller.
// Combines the register bank, per-pin drivers and the segment mapping.
// Assumes: synchronous active-low reset, single clock domain.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int NUM_PINS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [REG_AW-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [WIDTH-1:0]            bus_wdata,
    output logic [WIDTH-1:0]            bus_rdata,
    input  logic [WIDTH-1:0]            alt_in,
    output logic [WIDTH-1:0]            pad_out,
    output logic [WIDTH-1:0]            pad_oe,
    output logic [WIDTH-1:0]            pad_slow,
    output logic [WIDTH-1:0]            pad_lvl,
    output logic [NUM_PHASES*WIDTH-1:0] seg_bus
);

    localparam logic [WIDTH-1:0] IMPL_MASK = WIDTH'(low_mask(NUM_PINS));

    logic [WIDTH-1:0] mode_q, data_q, tri_q, spec_q, dpd_q, slow_q, lvl_q;

    gpio_regbank #(.WIDTH(WIDTH), .NUM_PINS(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wr_data (bus_wdata),
        .rd_data (bus_rdata),
        .mode_q  (mode_q),
        .data_q  (data_q),
        .tri_q   (tri_q),
        .spec_q  (spec_q),
        .dpd_q   (dpd_q),
        .slow_q  (slow_q),
        .lvl_q   (lvl_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i < NUM_PINS) begin : g_impl
            gpio_pin_drive u_drv (
                .lcd_mode  (mode_q[i]),
                .latch_val (data_q[i]),
                .tri_en    (tri_q[i]),
                .spec_en   (spec_q[i]),
                .dpd_en    (dpd_q[i]),
                .alt_val   (alt_in[i]),
                .pin_out   (pad_out[i]),
                .pin_oe    (pad_oe[i])
            );
        end else begin : g_absent
            assign pad_out[i] = 1'b0;
            assign pad_oe[i]  = 1'b0;
        end
    end

    // Pad control flags pass through for implemented pins only.
    assign pad_slow = slow_q & IMPL_MASK;
    assign pad_lvl  = lvl_q & IMPL_MASK;

    gpio_seg_map #(.WIDTH(WIDTH), .NUM_PINS(NUM_PINS)) u_seg (
        .mode_q (mode_q),
        .ph0    (data_q),
        .ph1    (tri_q),
        .ph2    (spec_q),
        .ph3    (dpd_q),
        .seg    (seg_bus)
    );

    AST_LCD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & mode_q) == '0)); // R8

    AST_TRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & tri_q) == '0)); // R5

    AST_DPD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & dpd_q) == '0)); // R7

    AST_UNIMPL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe | pad_out | bus_rdata) & ~IMPL_MASK) == '0)); // R3

endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

    localparam int W  = 8;
    localparam int NP = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [2:0]     bus_addr;
    logic           bus_wr;
    logic [W-1:0]   bus_wdata;
    logic [W-1:0]   bus_rdata;
    logic [W-1:0]   alt_in;
    logic [W-1:0]   pad_out, pad_oe, pad_slow, pad_lvl;
    logic [4*W-1:0] seg_bus;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference registers: 0 mode,1 data,2 tri,3 spec,4 dpd,5 slow,6 lvl
    logic [W-1:0] mreg [7];

    always #2 clk = ~clk;

    gpio_port_ctrl #(.WIDTH(W), .NUM_PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_in(alt_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_slow(pad_slow),
        .pad_lvl(pad_lvl), .seg_bus(seg_bus)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the behavioural model.
    task automatic compare_all();
        logic [W-1:0]   e_out, e_oe, e_rd;
        logic [4*W-1:0] e_seg;
        e_out = '0; e_oe = '0; e_seg = '0;
        for (int i = 0; i < NP; i++) begin
            logic s;
            s = mreg[3][i] ? alt_in[i] : mreg[1][i];
            if (mreg[0][i]) begin
                for (int k = 0; k < 4; k++) e_seg[4*i+k] = mreg[k+1][i];
            end else if (mreg[2][i]) begin
                e_oe[i] = 1'b0;
            end else if (mreg[4][i]) begin
                e_oe[i] = ~s;
            end else begin
                e_oe[i]  = 1'b1;
                e_out[i] = s;
            end
        end
        e_rd = (bus_addr < 3'd7) ? mreg[bus_addr] : '0;
        chk("R4/R6/R7/R8 pad_out", 64'(pad_out), 64'(e_out));
        chk("R4/R5/R7/R8 pad_oe", 64'(pad_oe), 64'(e_oe));
        chk("R8 seg_bus", 64'(seg_bus), 64'(e_seg));
        chk("R2/R3 bus_rdata", 64'(bus_rdata), 64'(e_rd));
        chk("R9 pad_slow", 64'(pad_slow), 64'(mreg[5]));
        chk("R9 pad_lvl", 64'(pad_lvl), 64'(mreg[6]));
    endtask

    // One cycle: set inputs after the falling edge, compare, then update model at the rising edge.
    task automatic step(input logic wr, input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] alt);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; alt_in = alt;
        #1 compare_all();
        @(posedge clk);
        if (wr && a < 3'd7) mreg[a] = d & W'((1 << NP) - 1);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; alt_in = '0;
        for (int r = 0; r < 7; r++) mreg[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state, all pins push-pull driving 0
        chk("R1 reset oe", 64'(pad_oe), 64'h3F);
        chk("R1 reset out", 64'(pad_out), 64'h00);
        chk("R1 reset seg", 64'(seg_bus), 64'h0);
        for (int a = 0; a < 8; a++) step(1'b0, 3'(a), '0, '0);
        // R4: push-pull values, R3: upper bits dropped
        step(1'b1, 3'd1, 8'hA5, '0);
        step(1'b0, 3'd1, '0, '0);
        // R5: tristate some pins
        step(1'b1, 3'd2, 8'h0F, '0);
        step(1'b0, 3'd2, '0, 8'hFF);
        step(1'b1, 3'd2, 8'h00, '0);
        // R6: special select with toggling alt_in
        step(1'b1, 3'd3, 8'h3C, 8'h55);
        step(1'b0, 3'd3, '0, 8'hAA);
        step(1'b0, 3'd3, '0, 8'h55);
        // R7: pull-down with both polarities
        step(1'b1, 3'd4, 8'hFF, 8'h0F);
        step(1'b0, 3'd4, '0, 8'hF0);
        // R8: LCD mode with distinct phase patterns
        step(1'b1, 3'd1, 8'h11, '0);
        step(1'b1, 3'd2, 8'h22, '0);
        step(1'b1, 3'd3, 8'h0C, '0);
        step(1'b1, 3'd4, 8'h30, '0);
        step(1'b1, 3'd0, 8'hF3, 8'hFF);
        step(1'b0, 3'd0, '0, '0);
        // R9: slow and level flags
        step(1'b1, 3'd5, 8'hC9, '0);
        step(1'b1, 3'd6, 8'h96, '0);
        step(1'b0, 3'd7, '0, '0);
        // Random streams of writes and alternate inputs
        for (int n = 0; n < 3000; n++)
            step(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                 W'($urandom), W'($urandom));
        // R1: mid-run reset clears everything
        @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
        @(posedge clk);
        for (int r = 0; r < 7; r++) mreg[r] = '0;
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 3'd0, '0, '0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule